// File: doc/BRIEF.md
# Hardware Load and Clear Pin Arbiter

This block sits between two asynchronous, active-low board pins and a four-channel register bank in which every channel has an input register and an output (DAC) register. The load pin copies input registers into output registers. The clear pin forces every output register to a programmable clear value. The block brings both pins into the system clock domain and finds their falling edges. It then applies the priority rules and issues one-cycle strobes: a per-channel load vector, a clear strobe with the value to write, and an abort pulse for the serial frame receiver.

A per-channel update mask chooses which channels answer the load pin. A two-bit clear select chooses the clear value. While a power-on reset is in progress, all pin activity is ignored. After a clear, the block stays in a clear hold state, in which loads are refused. The hold ends when a frame completes after the clear pin has returned high.

Top module: `pin_load_clear_arb`

## Requirements
- R1: After reset, `load_stb`, `clear_stb`, `frame_abort` and `clear_hold` are 0 and `clr_value` is all zeros.
- R2: A falling edge on `ld_pin_n` gives a one-cycle `load_stb` equal to the inverse of `upd_mask`. Bit i stands for channel i, and a mask bit of 1 excludes that channel. The strobe appears in the cycle after the third rising clock edge that follows the pin change.
- R3: While `ld_pin_n` is held low, each `frame_done` pulse gives a one-cycle `load_stb` equal to `~upd_mask` in the following cycle. With the pin high, `frame_done` gives no strobe.
- R4: When a load edge is detected in the same cycle as `frame_done`, a single `load_stb` pulse is issued one cycle later, after the frame's write.
- R5: A falling edge on `clr_pin_n` gives a one-cycle `clear_stb` and a one-cycle `frame_abort`, both at the same latency as R2. At the same time `clr_value` shows the selected value: `clr_sel` 2'b00 gives zero, 2'b01 gives midscale (MSB only), and 2'b10 or 2'b11 gives full scale (all ones).
- R6: While `clr_pin_n` is low, load edges and auto-loads produce no `load_stb`.
- R7: An accepted clear sets `clear_hold`. The hold blocks all loads. A `frame_done` while the clear pin is still low does not end the hold. The first `frame_done` after the pin has returned high clears the hold, and that frame gives no load.
- R8: When both pins fall in the same cycle, only the clear is acted on and `load_stb` stays 0.
- R9: While `por_busy` is 1, pin edges are ignored: no strobe, no abort and no hold.
- R10: Every strobe lasts exactly one clock cycle per pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_pin_n | input | 1 | Asynchronous active-low load pin |
| clr_pin_n | input | 1 | Asynchronous active-low clear pin |
| upd_mask | input | NCH | Per-channel load exclusion (1 = excluded) |
| clr_sel | input | 2 | Clear value select |
| por_busy | input | 1 | Power-on reset in progress |
| frame_done | input | 1 | One-cycle pulse when a valid frame completes |
| load_stb | output | NCH | Per-channel copy strobe |
| clear_stb | output | 1 | Clear-all strobe |
| clr_value | output | DW | Value to write on clear |
| frame_abort | output | 1 | Abort pulse for the frame receiver |
| clear_hold | output | 1 | Clear hold state active |

## Verification
A stuck or missing synchronizer stage shows up as a strobe one cycle early or late, or as none at all. The bench samples at an exact cycle count, so this is caught at the first pin edge. A hold flag that is wrongly cleared or set appears within one frame, as a load that should have been refused or one that never comes. Broken priority appears at once as load and clear strobes together. A wrong mask or a wrong clear encoding shows in the bit pattern in the same cycle as the strobe.

// File: rtl/plca_pkg.sv
package plca_pkg;
   typedef enum logic [1:0] {
      CS_ZERO  = 2'b00,
      CS_MID   = 2'b01,
      CS_FULL  = 2'b10,
      CS_FULL2 = 2'b11
   } clr_sel_e;
endpackage

// File: rtl/plca_sync.sv
module plca_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic lvl_low,
   output logic fall
);
   localparam int LAST = STAGES;

   generate
      if (STAGES < 2) begin : g_bad
         $error("plca_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[LAST-1:0], pin_n};
   end

   assign lvl_low = ~chain[LAST-1];
   assign fall    = chain[LAST] & ~chain[LAST-1];

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R10
endmodule

// File: rtl/plca_load_gen.sv
module plca_load_gen #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_fall,
   input  logic           ld_low,
   input  logic           frame_done,
   input  logic           block,
   input  logic           por_busy,
   input  logic [NCH-1:0] upd_mask,
   output logic [NCH-1:0] load_stb
);
   logic trig;

   assign trig = (ld_fall | (ld_low & frame_done)) & ~block & ~por_busy;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) load_stb[i] <= 1'b0;
            else        load_stb[i] <= trig & ~upd_mask[i];
         end
      end
   endgenerate

   AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (|load_stb) |-> ((load_stb & $past(upd_mask)) == '0)); // R2
   AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      block |=> (load_stb == '0)); // R6
endmodule

// File: rtl/plca_clear_ctl.sv
module plca_clear_ctl #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_fall,
   input  logic          clr_low,
   input  logic          por_busy,
   input  logic          frame_done,
   input  logic [1:0]    clr_sel,
   output logic          clear_stb,
   output logic          frame_abort,
   output logic [DW-1:0] clr_value,
   output logic          clear_hold
);
   import plca_pkg::*;

   localparam logic [DW-1:0] VAL_MID = {1'b1, {(DW-1){1'b0}}};

   generate
      if (DW < 2) begin : g_bad
         $error("plca_clear_ctl: DW must be at least 2");
      end
   endgenerate

   logic          accept;
   logic [DW-1:0] code_val;

   assign accept = clr_fall & ~por_busy;

   always_comb begin
      case (clr_sel_e'(clr_sel))
         CS_ZERO: code_val = '0;
         CS_MID:  code_val = VAL_MID;
         default: code_val = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clear_stb   <= 1'b0;
         frame_abort <= 1'b0;
         clr_value   <= '0;
         clear_hold  <= 1'b0;
      end else begin
         clear_stb   <= accept;
         frame_abort <= accept;
         if (accept) begin
            clr_value  <= code_val;
            clear_hold <= 1'b1;
         end else if (clear_hold && frame_done && !clr_low) begin
            clear_hold <= 1'b0;
         end
      end
   end

   AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> clear_hold); // R7
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_hold && clr_low) |=> clear_hold); // R7
   AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      clear_stb |=> !clear_stb); // R10
endmodule

// File: rtl/pin_load_clear_arb.sv
module pin_load_clear_arb #(
   parameter int NCH         = 4,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_pin_n,
   input  logic           clr_pin_n,
   input  logic [NCH-1:0] upd_mask,
   input  logic [1:0]     clr_sel,
   input  logic           por_busy,
   input  logic           frame_done,
   output logic [NCH-1:0] load_stb,
   output logic           clear_stb,
   output logic [DW-1:0]  clr_value,
   output logic           frame_abort,
   output logic           clear_hold
);
   generate
      if (NCH < 1) begin : g_bad
         $error("pin_load_clear_arb: NCH must be at least 1");
      end
   endgenerate

   logic ld_low, ld_fall, clr_low, clr_fall, ld_block;

   plca_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(ld_pin_n),
      .lvl_low(ld_low), .fall(ld_fall));

   plca_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(clr_pin_n),
      .lvl_low(clr_low), .fall(clr_fall));

   plca_clear_ctl #(.DW(DW)) u_clear (
      .clk(clk), .rst_n(rst_n), .clr_fall(clr_fall), .clr_low(clr_low),
      .por_busy(por_busy), .frame_done(frame_done), .clr_sel(clr_sel),
      .clear_stb(clear_stb), .frame_abort(frame_abort),
      .clr_value(clr_value), .clear_hold(clear_hold));

   // clear priority: a low clear pin or an active hold refuses any load
   assign ld_block = clr_low | clear_hold;

   plca_load_gen #(.NCH(NCH)) u_load (
      .clk(clk), .rst_n(rst_n), .ld_fall(ld_fall), .ld_low(ld_low),
      .frame_done(frame_done), .block(ld_block), .por_busy(por_busy),
      .upd_mask(upd_mask), .load_stb(load_stb));

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear_stb |-> (load_stb == '0)); // R8
   AST_POR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      por_busy |=> (!clear_stb && !frame_abort && load_stb == '0)); // R9
   AST_ABORT_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_abort |-> clear_hold); // R5
endmodule

// File: tb/sim_pin_load_clear_arb.sv
module sim_pin_load_clear_arb;
   localparam int  NCH   = 4;
   localparam int  DW    = 16;
   localparam time T_CLK = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ld_pin_n = 1'b1, clr_pin_n = 1'b1;
   logic [NCH-1:0] upd_mask = '0;
   logic [1:0]     clr_sel = 2'b00;
   logic           por_busy = 1'b0, frame_done = 1'b0;
   logic [NCH-1:0] load_stb;
   logic           clear_stb, frame_abort, clear_hold;
   logic [DW-1:0]  clr_value;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(T_CLK/2) clk = ~clk;

   pin_load_clear_arb #(.NCH(NCH), .DW(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_pin_n(ld_pin_n), .clr_pin_n(clr_pin_n),
      .upd_mask(upd_mask), .clr_sel(clr_sel), .por_busy(por_busy),
      .frame_done(frame_done), .load_stb(load_stb), .clear_stb(clear_stb),
      .clr_value(clr_value), .frame_abort(frame_abort), .clear_hold(clear_hold));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // after a pin change at a negedge: three rising edges, then sample
   task automatic to_strobe();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_frame();
      @(negedge clk) frame_done = 1'b1;
      @(negedge clk) frame_done = 1'b0;
   endtask

   task automatic end_hold();
      clr_pin_n = 1'b1;
      idle(4);
      pulse_frame();
      idle(2);
   endtask

   task automatic t_reset();
      chk("R1 load_stb", 32'(load_stb), 0);
      chk("R1 clear_stb", 32'(clear_stb), 0);
      chk("R1 abort", 32'(frame_abort), 0);
      chk("R1 hold", 32'(clear_hold), 0);
      chk("R1 value", 32'(clr_value), 0);
   endtask

   task automatic t_edge_load();
      upd_mask = 4'b0101;
      @(negedge clk) ld_pin_n = 1'b0;
      to_strobe();
      chk("R2 edge load", 32'(load_stb), 32'h0000000A);
      @(negedge clk);
      chk("R10 load one cycle", 32'(load_stb), 0);
      ld_pin_n = 1'b1;
      idle(4);
   endtask

   task automatic t_auto_load();
      @(negedge clk) ld_pin_n = 1'b0;
      idle(6);
      upd_mask = 4'b0011;
      pulse_frame();
      chk("R3 auto load", 32'(load_stb), 32'h0000000C);
      @(negedge clk);
      chk("R3 auto one cycle", 32'(load_stb), 0);
      ld_pin_n = 1'b1;
      idle(4);
      pulse_frame();
      chk("R3 no auto when high", 32'(load_stb), 0);
      idle(2);
   endtask

   task automatic t_same_cycle();
      upd_mask = 4'b0000;
      @(negedge clk) ld_pin_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk) frame_done = 1'b1;
      @(negedge clk) frame_done = 1'b0;
      chk("R4 coincident load", 32'(load_stb), 32'h0000000F);
      @(negedge clk);
      chk("R4 single pulse", 32'(load_stb), 0);
      ld_pin_n = 1'b1;
      idle(4);
   endtask

   task automatic t_clear_values();
      logic [DW-1:0] exp_v [4];
      exp_v[0] = 16'h0000; exp_v[1] = 16'h8000;
      exp_v[2] = 16'hFFFF; exp_v[3] = 16'hFFFF;
      for (int s = 0; s < 4; s++) begin
         clr_sel = 2'(s);
         @(negedge clk) clr_pin_n = 1'b0;
         to_strobe();
         chk("R5 clear strobe", 32'(clear_stb), 1);
         chk("R5 abort", 32'(frame_abort), 1);
         chk("R5 clear value", 32'(clr_value), 32'(exp_v[s]));
         @(negedge clk);
         chk("R10 clear one cycle", 32'(clear_stb), 0);
         end_hold();
         chk("R7 hold released", 32'(clear_hold), 0);
      end
   endtask

   task automatic t_clear_blocks();
      logic [NCH-1:0] seen;
      upd_mask = 4'b0000;
      @(negedge clk) clr_pin_n = 1'b0;
      idle(6);
      ld_pin_n = 1'b0;
      seen = '0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         seen |= load_stb;
      end
      chk("R6 edge ignored while clear low", 32'(seen), 0);
      pulse_frame();
      chk("R6 no auto while clear low", 32'(load_stb), 0);
      chk("R7 hold kept while pin low", 32'(clear_hold), 1);
      clr_pin_n = 1'b1;
      idle(4);
      chk("R7 hold kept after pin rise", 32'(clear_hold), 1);
      pulse_frame();
      chk("R7 releasing frame loads nothing", 32'(load_stb), 0);
      chk("R7 hold ends", 32'(clear_hold), 0);
      pulse_frame();
      chk("R7 loads resume", 32'(load_stb), 32'h0000000F);
      ld_pin_n = 1'b1;
      idle(4);
   endtask

   task automatic t_simultaneous();
      @(negedge clk) begin ld_pin_n = 1'b0; clr_pin_n = 1'b0; end
      to_strobe();
      chk("R8 clear taken", 32'(clear_stb), 1);
      chk("R8 load dropped", 32'(load_stb), 0);
      ld_pin_n = 1'b1;
      end_hold();
   endtask

   task automatic t_por();
      logic [NCH-1:0] seen;
      logic           seen_c;
      por_busy = 1'b1;
      @(negedge clk) begin ld_pin_n = 1'b0; clr_pin_n = 1'b0; end
      seen = '0; seen_c = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         seen |= load_stb;
         seen_c |= clear_stb | frame_abort;
      end
      chk("R9 no load in por", 32'(seen), 0);
      chk("R9 no clear in por", 32'(seen_c), 0);
      chk("R9 no hold in por", 32'(clear_hold), 0);
      ld_pin_n = 1'b1; clr_pin_n = 1'b1;
      idle(4);
      por_busy = 1'b0;
      upd_mask = 4'b1000;
      @(negedge clk) ld_pin_n = 1'b0;
      to_strobe();
      chk("R9 load after por", 32'(load_stb), 32'h00000007);
      ld_pin_n = 1'b1;
      idle(4);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_edge_load();
      t_auto_load();
      t_same_cycle();
      t_clear_values();
      t_clear_blocks();
      t_simultaneous();
      t_por();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule